// File: doc/BRIEF.md
# Effective Bank Address Resolver

This unit sits between the address-generation stage of a processor with 16-bit registers and its 24-bit memory bus. For every access it takes a 16-bit base offset, an optional 16-bit index, a 3-bit code naming the kind of access, and an explicit bank byte for long forms. It produces the full 24-bit bus address one clock later. Each kind of access chooses its upper byte in its own way. Each also has its own rule for what happens when the low 16 bits overflow: the sum either wraps inside the chosen bank or carries into the bank byte.

The program bank and data bank registers live inside the unit and are loaded through single-cycle strobes. A load lands at the clock edge, so an access presented in the same cycle still sees the old value. An extra output flags a program-counter rollover during instruction fetch. A second output flags an access code that has no meaning.

Top module: `ebar_resolver`

## Requirements
- R1: After reset, `out_vld`, `out_err` and `out_pcwrap` are 0. Both bank registers hold 0x00.
- R2: An access presented with `acc_vld`=1 produces exactly one result with `out_vld`=1 on the following cycle. A cycle with `acc_vld`=0 gives `out_vld`=0 on the next cycle.
- R3: Code 1 (vector / plain indirect pointer) gives address {0x00, base}. The index is ignored.
- R4: Code 0 (program fetch) gives {PB, (base+index) mod 2^16}. The bank never increments. `out_pcwrap` is 1 exactly when base+index exceeds 0xFFFF.
- R5: Code 2 (stack) gives {0x00, (base+index) mod 2^16}, whatever PB and DB hold.
- R6: Code 3 (direct page) gives {0x00, (base+index) mod 2^16}, whatever PB and DB hold.
- R7: Code 4 (data) gives ({DB, base} + index) mod 2^24, so a carry out of bit 15 increments the bank.
- R8: Code 5 (long absolute, or long indirect result) gives ({acc_bank, base} + index) mod 2^24. DB has no effect.
- R9: Code 6 (indexed indirect jump pointer) gives {PB, (base+index) mod 2^16}, with `out_pcwrap`=0.
- R10: Code 7 is reserved. It gives address 0x000000 with `out_err`=1. Every other code gives `out_err`=0, and `out_pcwrap` is 0 for every code except 0.
- R11: A PB or DB load strobe updates the register at the clock edge. An access in the same cycle uses the old value, and the next access uses the new one.
- R12: With `idx_en`=0 the index input is treated as zero for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pb_ld | input | 1 | Program bank load strobe |
| pb_in | input | 8 | Program bank load value |
| db_ld | input | 1 | Data bank load strobe |
| db_in | input | 8 | Data bank load value |
| acc_vld | input | 1 | Access request valid |
| acc_cls | input | 3 | Access class code (0..6 defined, 7 reserved) |
| acc_base | input | 16 | Base offset (PC, SP, DP+operand, operand or pointer low word) |
| acc_idx | input | 16 | Index value |
| idx_en | input | 1 | Add the index when 1 |
| acc_bank | input | 8 | Explicit bank for long forms |
| out_vld | output | 1 | Result valid |
| out_addr | output | 24 | Resolved bus address |
| out_pcwrap | output | 1 | Program counter rolled over within its bank |
| out_err | output | 1 | Reserved access class seen |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid pipeline;
- bank zero for vector, stack and direct-page classes;
- the program bank held on fetch and on indexed jump pointers;
- the reserved-code result;
- the data bank load timing.

Only the bench scenarios show the rest:
- the arithmetic corner cases, meaning the 16-bit rollovers that must stay in bank and the carries that must cross into the next bank (including the wrap from 0xFFFFFF to 0);
- the same-cycle load-versus-access ordering, seen at the address output;
- the disabled-index behaviour.

// File: rtl/ebar_pkg.sv
package ebar_pkg;
  typedef enum logic [2:0] {
    CLS_PROG  = 3'd0,
    CLS_VEC   = 3'd1,
    CLS_STACK = 3'd2,
    CLS_DPAGE = 3'd3,
    CLS_DATA  = 3'd4,
    CLS_LONG  = 3'd5,
    CLS_IXJMP = 3'd6,
    CLS_RSVD  = 3'd7
  } acc_cls_e;
endpackage

// File: rtl/ebar_rst_sync.sv
module ebar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/ebar_bank_regs.sv
module ebar_bank_regs #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_ld,
  input  logic [BANK_W-1:0] pb_in,
  input  logic              db_ld,
  input  logic [BANK_W-1:0] db_in,
  output logic [BANK_W-1:0] pb_q,
  output logic [BANK_W-1:0] db_q
);
  logic [BANK_W-1:0] pb_d, db_d;

  always_comb begin
    pb_d = pb_q;
    db_d = db_q;
    if (pb_ld) pb_d = pb_in;
    if (db_ld) db_d = db_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q <= '0;
      db_q <= '0;
    end else begin
      pb_q <= pb_d;
      db_q <= db_d;
    end
  end

  // R11
  db_load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_ld |=> db_q == $past(db_in));

  // R11
  pb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_ld |=> $stable(pb_q));
endmodule

// File: rtl/ebar_addr_gen.sv
module ebar_addr_gen
  import ebar_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = OFS_W + BANK_W
) (
  input  acc_cls_e          cls,
  input  logic [OFS_W-1:0]  base,
  input  logic [OFS_W-1:0]  idx,
  input  logic              idx_en,
  input  logic [BANK_W-1:0] bank_x,
  input  logic [BANK_W-1:0] pb,
  input  logic [BANK_W-1:0] db,
  output logic [ADDR_W-1:0] addr,
  output logic              pcwrap,
  output logic              err
);
  logic [OFS_W-1:0]  idx_eff;
  logic [OFS_W:0]    short_sum;
  logic [OFS_W-1:0]  short_lo;
  logic [BANK_W-1:0] wide_bank;
  logic [ADDR_W-1:0] wide_sum;

  always_comb begin
    idx_eff   = idx_en ? idx : '0;
    short_sum = {1'b0, base} + {1'b0, idx_eff};
    short_lo  = short_sum[OFS_W-1:0];
    wide_bank = (cls == CLS_LONG) ? bank_x : db;
    wide_sum  = {wide_bank, base} + {{BANK_W{1'b0}}, idx_eff};
  end

  always_comb begin
    addr   = '0;
    pcwrap = 1'b0;
    err    = 1'b0;
    unique case (cls)
      CLS_PROG: begin
        addr   = {pb, short_lo};
        pcwrap = short_sum[OFS_W];
      end
      CLS_VEC:   addr = {{BANK_W{1'b0}}, base};
      CLS_STACK,
      CLS_DPAGE: addr = {{BANK_W{1'b0}}, short_lo};
      CLS_DATA,
      CLS_LONG:  addr = wide_sum;
      CLS_IXJMP: addr = {pb, short_lo};
      default:   err  = 1'b1;
    endcase
  end
endmodule

// File: rtl/ebar_resolver.sv
module ebar_resolver
  import ebar_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int CLS_W  = 3,
  localparam int ADDR_W = OFS_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_ld,
  input  logic [BANK_W-1:0] pb_in,
  input  logic              db_ld,
  input  logic [BANK_W-1:0] db_in,
  input  logic              acc_vld,
  input  logic [CLS_W-1:0]  acc_cls,
  input  logic [OFS_W-1:0]  acc_base,
  input  logic [OFS_W-1:0]  acc_idx,
  input  logic              idx_en,
  input  logic [BANK_W-1:0] acc_bank,
  output logic              out_vld,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_pcwrap,
  output logic              out_err
);
  logic              rst_n_s;
  logic [BANK_W-1:0] pb_q, db_q;
  logic [ADDR_W-1:0] gen_addr, addr_d;
  logic              gen_wrap, gen_err, wrap_d, err_d, vld_d;

  ebar_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  ebar_bank_regs #(.BANK_W(BANK_W)) u_banks (
    .clk   (clk),
    .rst_n (rst_n_s),
    .pb_ld (pb_ld),
    .pb_in (pb_in),
    .db_ld (db_ld),
    .db_in (db_in),
    .pb_q  (pb_q),
    .db_q  (db_q)
  );

  ebar_addr_gen #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_gen (
    .cls    (acc_cls_e'(acc_cls)),
    .base   (acc_base),
    .idx    (acc_idx),
    .idx_en (idx_en),
    .bank_x (acc_bank),
    .pb     (pb_q),
    .db     (db_q),
    .addr   (gen_addr),
    .pcwrap (gen_wrap),
    .err    (gen_err)
  );

  // next state: result registers load only when an access is presented
  always_comb begin
    vld_d  = acc_vld;
    addr_d = out_addr;
    wrap_d = out_pcwrap;
    err_d  = out_err;
    if (acc_vld) begin
      addr_d = gen_addr;
      wrap_d = gen_wrap;
      err_d  = gen_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_vld    <= 1'b0;
      out_addr   <= '0;
      out_pcwrap <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      out_vld    <= vld_d;
      out_addr   <= addr_d;
      out_pcwrap <= wrap_d;
      out_err    <= err_d;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc_vld |=> out_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_vld |=> !out_vld);

  // R3
  vec_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && acc_cls == CLS_VEC) |=>
      (out_addr[ADDR_W-1:OFS_W] == '0 && out_addr[OFS_W-1:0] == $past(acc_base)));

  // R5
  stack_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && (acc_cls == CLS_STACK || acc_cls == CLS_DPAGE)) |=>
      out_addr[ADDR_W-1:OFS_W] == '0);

  // R4
  prog_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && acc_cls == CLS_PROG) |=> out_addr[ADDR_W-1:OFS_W] == $past(pb_q));

  // R9
  ixjmp_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && acc_cls == CLS_IXJMP) |=>
      (!out_pcwrap && out_addr[ADDR_W-1:OFS_W] == $past(pb_q)));

  // R10
  rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && acc_cls == CLS_RSVD) |=> (out_err && out_addr == '0));

  // R10
  no_false_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_vld && acc_cls != CLS_RSVD) |=> !out_err);
endmodule

// File: tb/test_ebar_resolver.sv
`timescale 1ns/1ps
module test_ebar_resolver;
  typedef struct {
    logic [23:0] addr;
    logic        wrap;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pb_ld, db_ld, acc_vld, idx_en;
  logic [7:0]  pb_in, db_in, acc_bank;
  logic [2:0]  acc_cls;
  logic [15:0] acc_base, acc_idx;
  logic        out_vld, out_pcwrap, out_err;
  logic [23:0] out_addr;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb_q[$];
  logic [7:0] m_pb, m_db;

  always #2.5 clk = ~clk;

  ebar_resolver i_ebar_resolver (
    .clk(clk), .rst_n(rst_n),
    .pb_ld(pb_ld), .pb_in(pb_in), .db_ld(db_ld), .db_in(db_in),
    .acc_vld(acc_vld), .acc_cls(acc_cls), .acc_base(acc_base),
    .acc_idx(acc_idx), .idx_en(idx_en), .acc_bank(acc_bank),
    .out_vld(out_vld), .out_addr(out_addr),
    .out_pcwrap(out_pcwrap), .out_err(out_err)
  );

  function automatic exp_t model(input logic [2:0] c, input logic [15:0] b,
                                 input logic [15:0] x, input logic e,
                                 input logic [7:0] k, input logic [7:0] pb,
                                 input logic [7:0] db);
    exp_t r;
    int unsigned i, s;
    i = e ? 32'(x) : 0;
    s = 32'(b) + i;
    r.addr = '0; r.wrap = 1'b0; r.err = 1'b0;
    case (c)
      3'd0: begin r.addr = 24'(pb * 65536 + s % 65536); r.wrap = (s > 65535); end
      3'd1: r.addr = 24'(b);
      3'd2, 3'd3: r.addr = 24'(s % 65536);
      3'd4: r.addr = 24'((db * 65536 + s) % 16777216);
      3'd5: r.addr = 24'((k * 65536 + s) % 16777216);
      3'd6: r.addr = 24'(pb * 65536 + s % 65536);
      default: r.err = 1'b1;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: called at a falling edge, pushes the expected result
  task automatic issue(input logic [2:0] c, input logic [15:0] b, input logic [15:0] x,
                       input logic e, input logic [7:0] k, input string tag,
                       input bit lp = 0, input logic [7:0] pv = 0,
                       input bit ld = 0, input logic [7:0] dv = 0);
    exp_t r;
    acc_vld = 1; acc_cls = c; acc_base = b; acc_idx = x; idx_en = e; acc_bank = k;
    pb_ld = lp; pb_in = pv; db_ld = ld; db_in = dv;
    r = model(c, b, x, e, k, m_pb, m_db);
    r.tag = tag;
    sb_q.push_back(r);
    @(negedge clk);
    if (lp) m_pb = pv;
    if (ld) m_db = dv;
    pb_ld = 0; db_ld = 0;
  endtask

  task automatic idle(input int n);
    acc_vld = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit lp, input logic [7:0] pv, input bit ld, input logic [7:0] dv);
    acc_vld = 0; pb_ld = lp; pb_in = pv; db_ld = ld; db_in = dv;
    @(negedge clk);
    if (lp) m_pb = pv;
    if (ld) m_db = dv;
    pb_ld = 0; db_ld = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (out_vld && !done) begin
        if (sb_q.size() == 0) begin
          check(0, "R2", "unexpected valid", 32'(out_vld), 0);
        end else begin
          exp_t r;
          r = sb_q.pop_front();
          check(out_addr == r.addr, r.tag, "addr", 32'(out_addr), 32'(r.addr));
          check(out_pcwrap == r.wrap, r.tag, "pcwrap", 32'(out_pcwrap), 32'(r.wrap));
          check(out_err == r.err, r.tag, "err", 32'(out_err), 32'(r.err));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R2", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; pb_ld = 0; db_ld = 0; acc_vld = 0; idx_en = 0;
    pb_in = 0; db_in = 0; acc_cls = 0; acc_base = 0; acc_idx = 0; acc_bank = 0;
    m_pb = 0; m_db = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check(out_vld == 0 && out_err == 0 && out_pcwrap == 0, "R1", "reset outputs",
          {29'd0, out_vld, out_err, out_pcwrap}, 0);
    // R1: banks start at zero
    issue(3'd0, 16'h4000, 16'h0000, 0, 8'h00, "R1");
    issue(3'd4, 16'h5678, 16'h0000, 0, 8'h00, "R1");
    load(1, 8'h12, 1, 8'h34);
    // R4
    issue(3'd0, 16'h1000, 16'h0003, 1, 8'h99, "R4");
    issue(3'd0, 16'hFFFE, 16'h0005, 1, 8'h99, "R4");
    issue(3'd0, 16'hFFFF, 16'h0001, 1, 8'h00, "R4");
    // R12
    issue(3'd0, 16'hFFFE, 16'h0005, 0, 8'h00, "R12");
    issue(3'd4, 16'hFFF0, 16'h0020, 0, 8'h00, "R12");
    // R3
    issue(3'd1, 16'hFFFC, 16'h0007, 1, 8'hAA, "R3");
    // R5, R6
    issue(3'd2, 16'h01FF, 16'hFF10, 1, 8'h77, "R5");
    issue(3'd3, 16'hFF00, 16'h0120, 1, 8'h77, "R6");
    // R7
    issue(3'd4, 16'hFFF0, 16'h0020, 1, 8'h00, "R7");
    issue(3'd4, 16'h1234, 16'h0000, 1, 8'h00, "R7");
    // R8
    issue(3'd5, 16'h1234, 16'h0000, 0, 8'hAB, "R8");
    issue(3'd5, 16'hFFFF, 16'h0001, 1, 8'hFF, "R8");
    issue(3'd5, 16'h8000, 16'h8001, 1, 8'h56, "R8");
    // R9
    issue(3'd6, 16'hFFFF, 16'h0002, 1, 8'h00, "R9");
    // R10
    issue(3'd7, 16'h1234, 16'h5678, 1, 8'hCD, "R10");
    // R11: same-cycle load uses old bank, next access new bank
    issue(3'd4, 16'h0100, 16'h0000, 0, 8'h00, "R11", 0, 0, 1, 8'h55);
    issue(3'd4, 16'h0100, 16'h0000, 0, 8'h00, "R11");
    issue(3'd0, 16'h0200, 16'h0000, 0, 8'h00, "R11", 1, 8'h3C, 0, 0);
    issue(3'd6, 16'h0200, 16'h0000, 0, 8'h00, "R11");
    issue(3'd8 - 3'd1, 16'h0, 16'h0, 0, 8'h0, "R10");
    // R2: gap, then mixed sweep
    idle(2);
    #1;
    check(out_vld == 0, "R2", "valid drops when idle", 32'(out_vld), 0);
    for (int j = 0; j < 24; j++) begin
      issue(3'(j % 8), 16'(j * 16'h2B7F + 16'hF000), 16'(j * 16'h1111),
            1'(j % 3 != 0), 8'(j * 37), "R2");
      if (j % 5 == 4) idle(1);
    end
    idle(3);
    check(sb_q.size() == 0, "R2", "results outstanding", 32'(sb_q.size()), 0);
    done = 1;
    finish_run();
  end
endmodule